// File: doc/BRIEF.md
# Priority-Level Interrupt Resolver

This block collects up to 32 interrupt lines into a pending register and gates them with a software-written enable mask. Lines are not ranked one against another. Instead, each priority level owns a fixed bitmask of member lines, and the block reports the highest level whose members include at least one line that is both pending and enabled. That level must also lie strictly above a software-set current level. A processor core uses the result, a request flag and a three-bit level number, to decide whether to take an interrupt and at which level.

Each line is built as either level-type or edge-type. A level-type line's pending bit follows its input. An edge-type line's pending bit is set by the input and then holds until software clears it. The line count, the level count (1 to 7), the edge-type selection and the level membership masks are elaboration-time parameters. A single write port, chosen by a two-bit select, updates the enable mask, updates the current level, or clears pending bits.

Top module: `irq_level_resolver`

## Requirements
- R1: After a synchronous reset, the pending bits and enable mask are all zero, the current level is 0, and `req_o` is 0 and `level_o` is 0.
- R2: A line contributes only when its pending bit and its enable bit are both 1. A pending line stays pending while disabled and takes effect once its enable bit is written to 1.
- R3: `level_o` is the largest level L, with 1 ≤ L ≤ NUM_LEVELS, whose membership mask shares a bit with the set of pending enabled lines and for which L is above the current level. A line that belongs to several levels makes all of them eligible.
- R4: When no level qualifies, including when the current level is NUM_LEVELS or more, `req_o` is 0 and `level_o` is 0.
- R5: For a level-type line, the pending bit equals the line's input sampled at the last clock edge. A deasserted input clears it.
- R6: For an edge-type line, the pending bit is set by a high input and stays set after the input falls. It is cleared only by a clear write (`wr_sel` = 2) with that bit set in `wr_data`. A high input in the same cycle wins over the clear. A clear write has no effect on level-type lines.
- R7: Input, enable and clear bits at index NUM_LINES or above are ignored and never produce a request.
- R8: Both outputs are registered. They change at the first clock edge after an input change or a write, reflecting the state that edge produces, and they hold their old value before that edge.
- R9: A write with `wr_sel` = 0 loads the enable mask from `wr_data`. A write with `wr_sel` = 1 loads the current level from `wr_data[2:0]`. A write with `wr_sel` = 3 changes nothing.
- R10: `req_o` is 1 exactly when `level_o` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Interrupt lines, active high |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 2 | Write target: 0 enable, 1 current level, 2 clear pending, 3 reserved |
| wr_data | input | 32 | Write data |
| req_o | output | 1 | Interrupt request above the current level |
| level_o | output | 3 | Level being requested, 0 when none |

## Verification
A corrupted pending, enable or current-level register shows up at `level_o` on the very next clock edge, because the outputs are recomputed every cycle from the state that edge produces. The sweeps therefore compare the level after every single step against a bench model, across all current levels and a dense spread of line patterns. Edge-type retention errors stay hidden until the line's input falls. For that reason the directed cases drop the input and then look for the held level, a cleared level, and the case where a high input beats a clear.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;

    localparam int MAX_LINES  = 32;
    localparam int MAX_LEVELS = 7;
    localparam int LVL_W      = 3;

    typedef logic [MAX_LINES-1:0] line_vec_t;
    typedef logic [LVL_W-1:0]     lvl_t;
    typedef logic [MAX_LEVELS:0]  hit_vec_t;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_LEVEL  = 2'd1,
        SEL_CLEAR  = 2'd2,
        SEL_RSVD   = 2'd3
    } wr_sel_e;

    typedef struct packed {
        logic req;
        lvl_t lvl;
    } grant_t;

    // Highest index among set hit bits; bit 0 is never a valid level.
    function automatic lvl_t pick_top(input hit_vec_t hits);
        lvl_t r;
        r = '0;
        for (int i = 1; i <= MAX_LEVELS; i++) begin
            if (hits[i]) r = lvl_t'(i);
        end
        return r;
    endfunction

    function automatic line_vec_t valid_mask(input int n);
        logic [MAX_LINES:0] w;
        w = ({{MAX_LINES{1'b0}}, 1'b1} << n) - 1'b1;
        return w[MAX_LINES-1:0];
    endfunction

endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irq_level_pkg::*;
#(
    parameter int NUM_LINES = 12
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic [1:0] wr_sel,
    input  line_vec_t wr_data,
    output line_vec_t en_next,
    output lvl_t      cur_next,
    output lvl_t      cur_q,
    output line_vec_t clr_mask
);
    localparam line_vec_t VALID = valid_mask(NUM_LINES);

    line_vec_t en_q;
    wr_sel_e   sel;

    assign sel = wr_sel_e'(wr_sel);

    always_comb begin
        en_next  = en_q;
        cur_next = cur_q;
        clr_mask = '0;
        if (wr_en) begin
            case (sel)
                SEL_ENABLE: en_next  = wr_data & VALID;
                SEL_LEVEL:  cur_next = wr_data[LVL_W-1:0];
                SEL_CLEAR:  clr_mask = wr_data & VALID;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            cur_q <= '0;
        end else begin
            en_q  <= en_next;
            cur_q <= cur_next;
        end
    end

    // R9: a reserved-select write leaves both registers untouched
    a_r9_reserved_inert: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_RSVD) |=> (en_q == $past(en_q) && cur_q == $past(cur_q)));

endmodule

// File: rtl/irq_pend_store.sv
module irq_pend_store
    import irq_level_pkg::*;
#(
    parameter int        NUM_LINES  = 12,
    parameter line_vec_t EDGE_LINES = 32'h0000_0A5A
) (
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t irq_in,
    input  line_vec_t clr_mask,
    output line_vec_t pend_next,
    output line_vec_t pend_q
);
    localparam line_vec_t VALID  = valid_mask(NUM_LINES);
    localparam line_vec_t EDGE_M = EDGE_LINES & VALID;

    // A high input always sets; edge lines otherwise keep their bit unless cleared.
    assign pend_next = VALID & (irq_in | (pend_q & EDGE_M & ~clr_mask));

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_next;
    end

    // R5: level-type bits mirror the input of the previous cycle
    a_r5_level_follows: assert property (@(posedge clk) disable iff (rst)
        ((pend_q ^ ($past(irq_in) & VALID)) & ~EDGE_M) == '0);

    // R6: an edge-type bit only falls when a clear targeted it
    a_r6_edge_holds: assert property (@(posedge clk) disable iff (rst)
        (($past(pend_q) & ~$past(clr_mask) & EDGE_M) & ~pend_q) == '0);

endmodule

// File: rtl/irq_level_scan.sv
module irq_level_scan
    import irq_level_pkg::*;
#(
    parameter int                           NUM_LEVELS  = 4,
    parameter logic [MAX_LEVELS*MAX_LINES-1:0] LEVEL_MASKS = '0
) (
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t pend_next,
    input  line_vec_t en_next,
    input  lvl_t      cur_next,
    output grant_t    grant_q
);
    line_vec_t eff;
    hit_vec_t  hits;
    grant_t    grant_d;

    assign eff     = pend_next & en_next;
    assign hits[0] = 1'b0;

    for (genvar L = 1; L <= MAX_LEVELS; L++) begin : g_lvl
        if (L <= NUM_LEVELS) begin : g_on
            localparam line_vec_t MEMBERS = LEVEL_MASKS[(L-1)*MAX_LINES +: MAX_LINES];
            assign hits[L] = (lvl_t'(L) > cur_next) && ((MEMBERS & eff) != '0);
        end else begin : g_off
            assign hits[L] = 1'b0;
        end
    end

    assign grant_d.req = |hits;
    assign grant_d.lvl = pick_top(hits);

    always_ff @(posedge clk) begin
        if (rst) grant_q <= '0;
        else     grant_q <= grant_d;
    end

endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
    import irq_level_pkg::*;
#(
    parameter int        NUM_LINES  = 12,
    parameter int        NUM_LEVELS = 4,
    parameter line_vec_t EDGE_LINES = 32'h0000_0A5A,
    parameter logic [MAX_LEVELS*MAX_LINES-1:0] LEVEL_MASKS =
        {32'h0, 32'h0, 32'h0, 32'h0000_0801, 32'h0000_0700, 32'h0000_00F0, 32'h0000_000F}
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] irq_in,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic        req_o,
    output logic [2:0]  level_o
);
    localparam lvl_t TOP_LVL = lvl_t'(NUM_LEVELS);

    line_vec_t en_next, clr_mask, pend_next, pend_q;
    lvl_t      cur_next, cur_q;
    grant_t    grant_q;

    irq_ctrl_regs #(.NUM_LINES(NUM_LINES)) u_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .en_next(en_next), .cur_next(cur_next), .cur_q(cur_q), .clr_mask(clr_mask)
    );

    irq_pend_store #(.NUM_LINES(NUM_LINES), .EDGE_LINES(EDGE_LINES)) u_pend (
        .clk(clk), .rst(rst), .irq_in(irq_in), .clr_mask(clr_mask),
        .pend_next(pend_next), .pend_q(pend_q)
    );

    irq_level_scan #(.NUM_LEVELS(NUM_LEVELS), .LEVEL_MASKS(LEVEL_MASKS)) u_scan (
        .clk(clk), .rst(rst), .pend_next(pend_next), .en_next(en_next),
        .cur_next(cur_next), .grant_q(grant_q)
    );

    assign req_o   = grant_q.req;
    assign level_o = grant_q.lvl;

    // R10: request and nonzero level travel together
    a_r10_req_level: assert property (@(posedge clk) disable iff (rst)
        req_o == (level_o != '0));

    // R4: a reported level is always above the stored current level
    a_r4_above_cur: assert property (@(posedge clk) disable iff (rst)
        req_o |-> (level_o > cur_q));

    // R3: never a level beyond those configured
    a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
        level_o <= TOP_LVL);

    // R7: unused lines never become pending
    a_r7_unused_idle: assert property (@(posedge clk) disable iff (rst)
        (pend_q & ~valid_mask(NUM_LINES)) == '0);

endmodule

// File: tb/irq_level_resolver_bench.sv
`timescale 1ns/1ps
module irq_level_resolver_bench;

    localparam int          NL    = 12;
    localparam int          NLV   = 4;
    localparam logic [31:0] EDGE  = 32'h0000_0A5A;
    localparam logic [223:0] MASKS =
        {32'h0, 32'h0, 32'h0, 32'h0000_0801, 32'h0000_0700, 32'h0000_00F0, 32'h0000_000F};
    localparam logic [31:0] VALID = 32'h0000_0FFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        req_o;
    logic [2:0]  level_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] pend_m = '0, en_m = '0;
    logic [2:0]  cur_m = '0;

    always #10 clk = ~clk;

    irq_level_resolver #(.NUM_LINES(NL), .NUM_LEVELS(NLV), .EDGE_LINES(EDGE),
        .LEVEL_MASKS(MASKS)) u_irq_level_resolver (
        .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .req_o(req_o), .level_o(level_o)
    );

    function automatic logic [2:0] exp_lvl();
        for (int L = NLV; L >= 1; L--) begin
            if (L > int'(cur_m) && ((MASKS[(L-1)*32 +: 32] & pend_m & en_m) != 0))
                return 3'(L);
        end
        return 3'd0;
    endfunction

    task automatic check(input string tag);
        logic [2:0] e;
        e = exp_lvl();
        checks++;
        if (level_o !== e || req_o !== (e != 0)) begin
            errors++;
            $display("FAIL %s level_o=%0d req_o=%0d expected level=%0d req=%0d",
                     tag, level_o, req_o, e, (e != 0));
        end
    endtask

    // Drive at a negative edge, let one rising edge pass, update the model, check.
    task automatic step(input logic [31:0] irq, input logic we, input logic [1:0] sel,
                        input logic [31:0] data, input string tag, input bit hold_chk = 0);
        logic [31:0] clr;
        irq_in = irq; wr_en = we; wr_sel = sel; wr_data = data;
        if (hold_chk) begin
            #2;
            check("R8 hold before edge");
        end
        @(posedge clk);
        clr = (we && sel == 2'd2) ? data : 32'h0;
        pend_m = VALID & (irq | (pend_m & EDGE & ~clr));
        if (we && sel == 2'd0) en_m = data & VALID;
        if (we && sel == 2'd1) cur_m = data[2:0];
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset state");

        // R2: edge line 4 (level 2) pulsed while disabled
        step(32'h0000_0010, 0, 0, 0, "R2 disabled pending silent");
        step(32'h0, 0, 0, 0, "R6 edge bit retained while disabled");
        step(32'h0, 1, 0, 32'hFFFF_FFFF, "R2 enable exposes held pending");
        // R6: clear write removes it
        step(32'h0, 1, 2'd2, 32'h0000_0010, "R6 clear edge bit");
        // R6: input high beats clear
        step(32'h0000_0010, 1, 2'd2, 32'h0000_0010, "R6 input wins over clear");
        step(32'h0, 1, 2'd2, 32'hFFF, "R6 clear all edge");
        // R5 and R6: level line 2 (level 1) ignores clear, drops with input
        step(32'h0000_0004, 0, 0, 0, "R5 level line asserts", 1);
        step(32'h0000_0004, 1, 2'd2, 32'h0000_0004, "R6 clear ignored on level line");
        step(32'h0, 0, 0, 0, "R5 level line drops");
        // R3: line 0 is in levels 1 and 4
        step(32'h0000_0001, 1, 2'd1, 32'd3, "R3 shared line reaches level 4");
        step(32'h0000_0301, 1, 2'd1, 32'd4, "R4 current level at top");
        step(32'h0000_0301, 1, 2'd1, 32'd0, "R3 highest of several");
        // R7: lines beyond the count
        step(32'hFFFF_F000, 1, 2'd0, 32'hFFFF_FFFF, "R7 unused inputs ignored");
        step(32'h0000_0FFF, 1, 2'd0, 32'hFFFF_F000, "R7 unused enable bits ignored");
        // R9: reserved write
        step(32'h0000_0100, 1, 2'd0, 32'hFFF, "R9 enable write");
        step(32'h0000_0100, 1, 2'd3, 32'hFFFF_FFFF, "R9 reserved write inert");
        step(32'h0000_0100, 1, 2'd1, 32'd7, "R4 level 7 masks all");
        step(32'h0, 1, 2'd2, 32'hFFF, "R8 registered update");

        // Sweep: all current levels, dense line patterns, all enabled
        for (int c = 0; c < 8; c++) begin
            step(32'h0, 1, 2'd1, 32'(c), "R9 level write");
            for (int p = 0; p < 4096; p += 7)
                step(32'(p), 1, 2'd2, 32'hFFF, "R3 sweep");
        end
        // Partial enable sweep
        step(32'h0, 1, 2'd1, 32'd0, "R9 level write");
        step(32'h0, 1, 2'd0, 32'h5A5, "R2 partial enable");
        for (int p = 0; p < 4096; p += 5)
            step(32'(p), 1, 2'd2, 32'hFFF, "R2 masked sweep");
        // Edge accumulation without clears
        for (int p = 1; p < 4096; p = p * 3)
            step(32'(p) & 32'hFFF, 0, 0, 0, "R6 accumulate sweep");
        // Reset returns to idle
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        pend_m = '0; en_m = '0; cur_m = '0;
        irq_in = '0; wr_en = 0;
        check("R1 reset after activity");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule